// File: doc/BRIEF.md
# Nanosecond Alarm Timer

This peripheral keeps a free-running 64-bit count of nanoseconds and raises a level interrupt when that count reaches a programmed 64-bit alarm. It sits on a simple 32-bit read/write bus. The count advances by a fixed parameter amount on every clock and returns to zero on reset.

Software reads time as two 32-bit words. Reading the low word also copies the whole 64-bit count into a snapshot register. A later read of the high word returns the upper half of that snapshot, so the two halves always belong together. To set an alarm, software first stages the upper half and then writes the lower half. The lower-half write loads the full alarm and compares it, as a signed value, against the count. If the alarm time has already passed, the interrupt rises at once and the timer stays disarmed. Otherwise the timer arms and fires later, on its own.

Two write-only offsets drop the interrupt. The first leaves an armed alarm in place. The second also cancels that alarm. Any access to an offset outside the map does nothing and raises a one-cycle error pulse.

Top module: `ns_alarm_timer`

## Requirements
- R1: While reset is low, the count, the snapshot and the staged upper alarm half are zero, the timer is disarmed, and irqOut, accessErr and busRdata are 0.
- R2: On every clock with reset high, the count grows by STEP_NS. A read of offset 0x00 puts the low 32 bits of the count, as sampled at that clock edge, on busRdata on the following cycle.
- R3: A read of offset 0x00 copies all 64 bits of the count into the snapshot. A read of offset 0x04 returns the upper 32 bits of the snapshot, not of the live count.
- R4: A write to offset 0x0C only stages the upper alarm half. It changes neither irqOut nor the armed state, and it does not change the alarm that an armed timer is comparing against.
- R5: A write to offset 0x08 forms the alarm as {staged upper half, write data}. If that value, taken as signed, is less than or equal to the current count, irqOut is 1 on the next cycle and the timer stays disarmed.
- R6: If the alarm from R5 is later than the count, the timer arms. While it is armed, it fires on the first clock at which the signed count is greater than or equal to the alarm: it disarms and sets irqOut. It fires only once.
- R7: A write to offset 0x10 clears irqOut and leaves the armed state unchanged.
- R8: A write to offset 0x14 disarms the timer and clears irqOut.
- R9: Once set, irqOut stays at 1 until a write to 0x10 or 0x14.
- R10: An access is undefined if its offset has nonzero low two bits or lies above 0x14. A write to an undefined offset changes nothing. A read from an undefined offset returns 0. Either access sets accessErr to 1 for exactly the next cycle (when ERR_EN is 1). A read of 0x08..0x14 returns 0, and a write to 0x00 or 0x04 has no effect. Neither of these raises an error.
- R11: If an armed timer becomes due in the same cycle as a write to 0x10, irqOut ends at 1. If it becomes due in the same cycle as a write to 0x14 or 0x08, the written operation decides the outcome and the old alarm does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access strobe, one access per cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data, valid the cycle after a read, otherwise 0 |
| irqOut | output | 1 | Level interrupt |
| accessErr | output | 1 | One-cycle pulse after an undefined access |

## Verification
The assertions assume that the bus carries at most one access per cycle and that its inputs are stable at each rising edge. They also assume that reset is asserted from time zero and released only once. The bench changes busSel, busWr, busAddr and busWdata only on falling edges. It releases reset once, after several clocks. Random upper-half writes are drawn close to the live count, so that a mix of past and future alarms is produced. The bench runs with a large step, so the count crosses the 32-bit boundary within a few cycles.

// File: rtl/ns_alarm_timer_pkg.sv
`timescale 1ns/1ps
package ns_alarm_timer_pkg;

  // byte offsets of the register map
  localparam int OFF_TIME_LO   = 'h00;
  localparam int OFF_TIME_HI   = 'h04;
  localparam int OFF_ALARM_LO  = 'h08;
  localparam int OFF_ALARM_HI  = 'h0C;
  localparam int OFF_CLR_IRQ   = 'h10;
  localparam int OFF_CLR_ALARM = 'h14;

  // strobes from control to datapath
  typedef struct packed {
    logic readLow;
    logic readHigh;
    logic loadAlarmLo;
    logic loadAlarmHi;
  } tmrStrobe_t;

endpackage

// File: rtl/ns_alarm_timer_dp.sv
`timescale 1ns/1ps
module ns_alarm_timer_dp
  import ns_alarm_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter longint unsigned STEP_NS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [BUS_W-1:0]   busWdata,
  output logic [BUS_W-1:0]   busRdata,
  output logic [2*BUS_W-1:0] countNow,
  output logic               alarmDueNew,
  output logic               alarmDueLive
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

  logic [CNT_W-1:0] count;
  logic [BUS_W-1:0] snapHi;
  logic [BUS_W-1:0] alarmHiStage;
  logic [CNT_W-1:0] alarmValue;
  logic [CNT_W-1:0] candidate;

  assign countNow  = count;
  assign candidate = {alarmHiStage, busWdata};

  // signed comparisons against the live count
  assign alarmDueNew  = $signed(candidate) <= $signed(count);
  assign alarmDueLive = $signed(count) >= $signed(alarmValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      count <= count + STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapHi   <= '0;
      busRdata <= '0;
    end else begin
      if (strobe.readLow) begin
        snapHi   <= count[CNT_W-1:BUS_W];
        busRdata <= count[BUS_W-1:0];
      end else if (strobe.readHigh) begin
        busRdata <= snapHi;
      end else begin
        busRdata <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmHiStage <= '0;
      alarmValue   <= '0;
    end else begin
      if (strobe.loadAlarmHi) alarmHiStage <= busWdata;
      if (strobe.loadAlarmLo) alarmValue   <= candidate;
    end
  end

endmodule

// File: rtl/ns_alarm_timer_ctrl.sv
`timescale 1ns/1ps
module ns_alarm_timer_ctrl
  import ns_alarm_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter bit ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              alarmDueNew,
  input  logic              alarmDueLive,
  output tmrStrobe_t        strobe,
  output logic              armed,
  output logic              irqOut,
  output logic              accessErr
);
  logic hitTimeLo, hitTimeHi, hitAlarmLo, hitAlarmHi, hitClrIrq, hitClrAlarm;
  logic knownOff;
  logic wrClrIrq, wrClrAlarm;
  logic fireNow, setIrq;

  always_comb begin
    hitTimeLo   = busAddr == ADDR_W'(OFF_TIME_LO);
    hitTimeHi   = busAddr == ADDR_W'(OFF_TIME_HI);
    hitAlarmLo  = busAddr == ADDR_W'(OFF_ALARM_LO);
    hitAlarmHi  = busAddr == ADDR_W'(OFF_ALARM_HI);
    hitClrIrq   = busAddr == ADDR_W'(OFF_CLR_IRQ);
    hitClrAlarm = busAddr == ADDR_W'(OFF_CLR_ALARM);
    knownOff    = hitTimeLo | hitTimeHi | hitAlarmLo | hitAlarmHi | hitClrIrq | hitClrAlarm;

    strobe.readLow     = busSel & ~busWr & hitTimeLo;
    strobe.readHigh    = busSel & ~busWr & hitTimeHi;
    strobe.loadAlarmLo = busSel &  busWr & hitAlarmLo;
    strobe.loadAlarmHi = busSel &  busWr & hitAlarmHi;
    wrClrIrq           = busSel &  busWr & hitClrIrq;
    wrClrAlarm         = busSel &  busWr & hitClrAlarm;

    // a pending fire yields to a new alarm or a cancel in the same cycle
    fireNow = armed & alarmDueLive & ~wrClrAlarm & ~strobe.loadAlarmLo;
    setIrq  = fireNow | (strobe.loadAlarmLo & alarmDueNew);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (wrClrAlarm) begin
      armed <= 1'b0;
    end else if (strobe.loadAlarmLo) begin
      armed <= ~alarmDueNew;
    end else if (fireNow) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else if (setIrq) begin
      irqOut <= 1'b1;
    end else if (wrClrIrq | wrClrAlarm) begin
      irqOut <= 1'b0;
    end
  end

  generate
    if (ERR_EN) begin : g_err
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) accessErr <= 1'b0;
        else       accessErr <= busSel & ~knownOff;
      end
    end else begin : g_noErr
      assign accessErr = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ns_alarm_timer.sv
`timescale 1ns/1ps
module ns_alarm_timer
  import ns_alarm_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int ADDR_W = 12,
  parameter longint unsigned STEP_NS = 10,
  parameter bit ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqOut,
  output logic              accessErr
);
  localparam int CNT_W = 2 * BUS_W;

  tmrStrobe_t       strobe;
  logic             armed;
  logic             alarmDueNew;
  logic             alarmDueLive;
  logic [CNT_W-1:0] countNow;

  ns_alarm_timer_ctrl #(.ADDR_W(ADDR_W), .ERR_EN(ERR_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .alarmDueNew(alarmDueNew), .alarmDueLive(alarmDueLive),
    .strobe(strobe), .armed(armed), .irqOut(irqOut), .accessErr(accessErr)
  );

  ns_alarm_timer_dp #(.BUS_W(BUS_W), .STEP_NS(STEP_NS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .countNow(countNow),
    .alarmDueNew(alarmDueNew), .alarmDueLive(alarmDueLive)
  );

endmodule

// File: rtl/ns_alarm_timer_check.sv
`timescale 1ns/1ps
module ns_alarm_timer_check #(
  parameter int BUS_W = 32,
  parameter int ADDR_W = 12,
  parameter longint unsigned STEP_NS = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               irqOut,
  input logic               accessErr,
  input logic               armed,
  input logic [2*BUS_W-1:0] countNow
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

  logic wrClrIrq, wrClrAlarm, wrAlarmHi, badOff;
  assign wrClrIrq   = busSel && busWr && busAddr == ADDR_W'('h10);
  assign wrClrAlarm = busSel && busWr && busAddr == ADDR_W'('h14);
  assign wrAlarmHi  = busSel && busWr && busAddr == ADDR_W'('h0C);
  assign badOff     = (busAddr[1:0] != 2'b00) || (busAddr > ADDR_W'('h14));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (!irqOut && !armed && countNow == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> countNow == $past(countNow) + STEP);

  assert_hi_no_arm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrAlarmHi && !armed) |=> !armed);

  assert_clr_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrClrIrq && !armed) |=> (!irqOut && !armed));

  assert_clr_alarm_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrClrAlarm |=> (!irqOut && !armed));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !wrClrIrq && !wrClrAlarm) |=> irqOut);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(busSel && badOff));

endmodule

bind ns_alarm_timer ns_alarm_timer_check #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .STEP_NS(STEP_NS)
) chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .irqOut(irqOut), .accessErr(accessErr), .armed(armed), .countNow(countNow)
);

// File: tb/ns_alarm_timer_test.sv
`timescale 1ns/1ps
module ns_alarm_timer_test;
  localparam longint unsigned TB_STEP = 64'h0000_0000_6000_0005;
  localparam logic [63:0] STEP64 = 64'(TB_STEP);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        accessErr;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit finished = 0;

  // reference state built from the requirements
  logic [63:0] mCount = '0;
  logic [31:0] mSnap = '0, mHi = '0, mRd = '0;
  logic [63:0] mAlarm = '0;
  bit mArmed = 0, mIrq = 0, mErr = 0;
  string irqTag = "R9", rdTag = "R10";

  ns_alarm_timer #(.BUS_W(32), .ADDR_W(12), .STEP_NS(TB_STEP), .ERR_EN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .accessErr(accessErr)
  );

  always #2.5 clk = ~clk;

  function automatic bit isBad(input logic [11:0] a);
    return (a[1:0] != 2'b00) || (a > 12'h014);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = '0; mSnap = '0; mHi = '0; mRd = '0; mAlarm = '0;
      mArmed = 0; mIrq = 0; mErr = 0;
    end else begin
      logic [63:0] cand;
      bit due, fire, rd, wr;
      rd = busSel && !busWr;
      wr = busSel && busWr;
      cand = {mHi, busWdata};
      due = $signed(mCount) >= $signed(mAlarm);
      irqTag = "R9";
      // read path (R2 R3 R10)
      mRd = '0; rdTag = "R10";
      if (rd && busAddr == 12'h000) begin mRd = mCount[31:0]; mSnap = mCount[63:32]; rdTag = "R2"; end
      else if (rd && busAddr == 12'h004) begin mRd = mSnap; rdTag = "R3"; end
      mErr = busSel && isBad(busAddr);
      fire = mArmed && due;
      if (wr && busAddr == 12'h014) begin
        mArmed = 0; mIrq = 0; irqTag = fire ? "R11" : "R8";
      end else if (wr && busAddr == 12'h008) begin
        mAlarm = cand;
        if ($signed(cand) <= $signed(mCount)) begin mIrq = 1; mArmed = 0; irqTag = "R5"; end
        else begin mArmed = 1; irqTag = fire ? "R11" : "R6"; end
      end else if (fire) begin
        mArmed = 0; mIrq = 1; irqTag = (wr && busAddr == 12'h010) ? "R11" : "R6";
      end else if (wr && busAddr == 12'h010) begin
        mIrq = 0; irqTag = "R7";
      end
      if (wr && busAddr == 12'h00C) begin mHi = busWdata; irqTag = "R4"; end
      mCount = mCount + STEP64;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !finished) begin
      check(irqTag, 64'(irqOut), 64'(mIrq));
      check(rdTag, 64'(busRdata), 64'(mRd));
      check("R10 err", 64'(accessErr), 64'(mErr));
    end
  end

  task automatic busOp(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
    end
  endtask

  task automatic armAhead(input int cyclesAhead);
    logic [63:0] target;
    target = mCount + STEP64 * 64'(cyclesAhead);
    busOp(1'b1, 12'h00C, target[63:32]);
    busOp(1'b1, 12'h008, target[31:0]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq", 64'(irqOut), 64'd0);
    check("R1 rdata", 64'(busRdata), 64'd0);
    check("R1 err", 64'(accessErr), 64'd0);
    rstN = 1'b1;
    checking = 1;
    idle(6);
    // R2 R3: snapshot consistency, high word frozen
    busOp(1'b0, 12'h000, '0);
    busOp(1'b0, 12'h004, '0);
    idle(5);
    busOp(1'b0, 12'h004, '0);
    idle(2);
    // R6: future alarm fires once, then R7 clears
    armAhead(6);
    idle(12);
    busOp(1'b1, 12'h010, '0);
    idle(3);
    // R5: very negative alarm fires at once
    busOp(1'b1, 12'h00C, 32'h8000_0000);
    busOp(1'b1, 12'h008, 32'h0);
    idle(3);
    busOp(1'b1, 12'h014, '0);
    // R4: staging a past upper half alone does nothing
    busOp(1'b1, 12'h00C, 32'h0);
    idle(3);
    // far future alarm, R7 keeps it armed, R8 cancels
    busOp(1'b1, 12'h00C, 32'h7FFF_FFFF);
    busOp(1'b1, 12'h008, 32'hFFFF_FFFF);
    busOp(1'b1, 12'h010, '0);
    busOp(1'b1, 12'h00C, 32'h0);
    idle(3);
    busOp(1'b1, 12'h014, '0);
    idle(2);
    // R11: clear-interrupt writes across the fire cycle
    armAhead(4);
    for (int i = 0; i < 10; i++) busOp(1'b1, 12'h010, '0);
    idle(2);
    busOp(1'b1, 12'h010, '0);
    // R10: undefined offsets and wrong-direction accesses
    busOp(1'b0, 12'h018, '0);
    busOp(1'b1, 12'h01C, 32'hFFFF_FFFF);
    busOp(1'b0, 12'h002, '0);
    busOp(1'b0, 12'h008, '0);
    busOp(1'b1, 12'h000, 32'h1234_5678);
    idle(3);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int pick;
      pick = int'($urandom % 10);
      case (pick)
        0: a = 12'h000; 1: a = 12'h004; 2, 3: a = 12'h008; 4: a = 12'h00C;
        5: a = 12'h010; 6: a = 12'h014; 7: a = 12'h018; 8: a = 12'h003;
        default: a = 12'h000;
      endcase
      d = $urandom;
      if (a == 12'h00C) d = mCount[63:32] + 32'($urandom % 4);
      if (pick == 9) idle(1 + int'($urandom % 4));
      else busOp(1'(($urandom % 2) == 1 || a == 12'h008 || a == 12'h00C), a, d);
    end
    idle(4);
    summary();
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

endmodule